// File: doc/BRIEF.md
# Memory-Type-Aware Access Ordering Queue

This block sits between a processor's load/store stream and a bus. Requests arrive in program order, each tagged with a memory class: normal, device or strongly-ordered. The block holds them in a small compacting queue and decides which transaction goes out next. Strongly-ordered requests are kept in sequence with every other access. Device requests are kept in sequence with each other. Normal requests may move relative to other traffic.

Normal traffic has one optimisation. When the oldest queued entry is a normal half-word store, the block looks further back in the queue for a normal half-word store to the other half of the same aligned word. If it finds one, the two leave together as a single word write with merged byte enables. The younger store then overtakes any device entries that lie between the two. A strongly-ordered entry in between stops the search. So does a normal access to the same word.

Top module: `mem_order_queue`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A device (in_kind=1) or strongly-ordered (in_kind=2) request leaves as exactly one transaction. Its class, direction, address, size, byte enables and data are those it entered with.
- R3: Device and strongly-ordered requests leave in the order they were accepted.
- R4: A normal (in_kind=0) half-word (size=1) write at byte offset 0 of a word can merge with a younger normal half-word write at offset 2 of the same word, and the reverse case merges too. The pair then leaves, in the place of the older one, as one write with size=2 (word), the address aligned to the word, byte enables 4'b1111, and each byte's data taken from the request that enabled it.
- R5: Device entries lying between two merge partners do not prevent the merge. The younger normal store therefore passes them.
- R6: A strongly-ordered entry lying between two half-word stores prevents the merge, and all four requests leave in program order.
- R7: A normal access to the same aligned word lying between two half-word stores prevents the merge.
- R8: Reads, device half-word writes, and half-word writes to different words are never merged.
- R9: With DEPTH entries held, in_ready is 0. It returns to 1 once an entry has left.
- R10: While out_valid is 1 and out_ready is 0, out_valid stays 1 and the word part of out_addr (bits above bit 1) stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Queue can accept a request |
| in_kind | input | 2 | Memory class: 0 normal, 1 device, 2 strongly-ordered |
| in_write | input | 1 | 1 for store, 0 for load |
| in_addr | input | AW | Byte address |
| in_size | input | 2 | 0 byte, 1 half-word, 2 word |
| in_be | input | 4 | Byte enables within the word |
| in_data | input | 32 | Store data, already placed in its byte lanes |
| out_valid | output | 1 | Transaction offered to the bus |
| out_ready | input | 1 | Bus takes the transaction |
| out_kind | output | 2 | Class of the transaction |
| out_write | output | 1 | Direction of the transaction |
| out_addr | output | AW | Transaction address |
| out_size | output | 2 | Transaction size |
| out_be | output | 4 | Transaction byte enables |
| out_data | output | 32 | Transaction data |

## Verification
The bench builds the queue with DEPTH=4 and AW=16. Four entries are enough to hold a whole four-request ordering pattern while the bus is stalled. That lets the bench hold normal-device-device-normal and normal-strongly-ordered-strongly-ordered-normal sequences and check what comes out. The shallow depth also means the full condition and its recovery take only a few pushes. The 16-bit address keeps word-match and different-word cases easy to set up.

// File: rtl/mem_order_queue.sv
module mem_order_queue #(
  parameter int DEPTH = 4,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_kind,
  input  logic          in_write,
  input  logic [AW-1:0] in_addr,
  input  logic [1:0]    in_size,
  input  logic [3:0]    in_be,
  input  logic [31:0]   in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_kind,
  output logic          out_write,
  output logic [AW-1:0] out_addr,
  output logic [1:0]    out_size,
  output logic [3:0]    out_be,
  output logic [31:0]   out_data
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [1:0] K_NORM = 2'd0;
  localparam logic [1:0] K_SO   = 2'd2;

  typedef struct packed {
    logic [1:0]    kind;
    logic          wr;
    logic [AW-1:0] addr;
    logic [1:0]    size;
    logic [3:0]    be;
    logic [31:0]   data;
  } ent_t;

  ent_t             q   [DEPTH];
  ent_t             q_n [DEPTH];
  logic [DEPTH-1:0] vld, vld_n;

  logic          head_ok, merge, pop, push;
  logic [IW-1:0] mj;
  ent_t          part;

  assign head_ok = vld[0] && q[0].kind == K_NORM && q[0].wr &&
                   q[0].size == 2'd1 && !q[0].addr[0];

  always_comb begin
    logic blk, hit;
    blk = 1'b0;
    hit = 1'b0;
    mj  = '0;
    for (int j = 1; j < DEPTH; j++) begin
      if (vld[j] && !blk && !hit) begin
        if (q[j].kind == K_NORM && q[j].wr && q[j].size == 2'd1 && !q[j].addr[0] &&
            q[j].addr[AW-1:2] == q[0].addr[AW-1:2] && q[j].addr[1] != q[0].addr[1]) begin
          hit = 1'b1;
          mj  = IW'(j);
        end else if (q[j].kind == K_SO ||
                     (q[j].kind == K_NORM && q[j].addr[AW-1:2] == q[0].addr[AW-1:2])) begin
          blk = 1'b1;
        end
      end
    end
    merge = head_ok && hit;
  end

  assign part = q[mj];

  assign out_valid = vld[0];
  assign out_kind  = q[0].kind;
  assign out_write = q[0].wr;
  assign out_addr  = merge ? {q[0].addr[AW-1:2], 2'b00} : q[0].addr;
  assign out_size  = merge ? 2'd2 : q[0].size;
  assign out_be    = merge ? (q[0].be | part.be) : q[0].be;

  always_comb begin
    for (int b = 0; b < 4; b++)
      out_data[8*b +: 8] = (merge && !q[0].be[b]) ? part.data[8*b +: 8] : q[0].data[8*b +: 8];
  end

  assign in_ready = !vld[DEPTH-1];
  assign pop      = out_valid && out_ready;
  assign push     = in_valid && in_ready;

  always_comb begin
    int w;
    w = 0;
    for (int i = 0; i < DEPTH; i++) begin
      q_n[i]   = q[i];
      vld_n[i] = 1'b0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && !(pop && (i == 0 || (merge && i == int'(mj))))) begin
        q_n[w[IW-1:0]]   = q[i];
        vld_n[w[IW-1:0]] = 1'b1;
        w = w + 1;
      end
    end
    if (push && w < DEPTH) begin
      q_n[w[IW-1:0]]   = '{kind: in_kind, wr: in_write, addr: in_addr,
                           size: in_size, be: in_be, data: in_data};
      vld_n[w[IW-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else begin
      vld <= vld_n;
      for (int i = 0; i < DEPTH; i++) q[i] <= q_n[i];
    end
  end

  p_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind != K_NORM |-> !merge && out_size == q[0].size && out_be == q[0].be);

  p_merge_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    merge |-> out_size == 2'd2 && out_be == 4'hF && out_addr[1:0] == 2'b00);

  p_merge_norm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    merge |-> out_kind == K_NORM && out_write && part.kind == K_NORM);

  p_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld) == DEPTH |-> !in_ready);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr[AW-1:2]));
endmodule

// File: tb/tb_mem_order_queue.sv
module tb_mem_order_queue;
  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int EW    = 2 + 1 + AW + 2 + 4 + 32;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          in_valid = 0, out_ready = 0;
  logic          in_ready, out_valid;
  logic [1:0]    in_kind = 0, in_size = 0, out_kind, out_size;
  logic          in_write = 0, out_write;
  logic [AW-1:0] in_addr = 0, out_addr;
  logic [3:0]    in_be = 0, out_be;
  logic [31:0]   in_data = 0, out_data;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [EW-1:0] expq[$];
  string         tagq[$];

  always #5 clk = ~clk;

  mem_order_queue #(.DEPTH(DEPTH), .AW(AW)) dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_kind, .in_write, .in_addr, .in_size,
    .in_be, .in_data, .out_valid, .out_ready, .out_kind, .out_write, .out_addr,
    .out_size, .out_be, .out_data);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_tx(input string req, input logic [1:0] k, input logic w, input logic [AW-1:0] a,
                           input logic [1:0] s, input logic [3:0] b, input logic [31:0] d);
    expq.push_back({k, w, a, s, b, d});
    tagq.push_back(req);
  endtask

  task automatic put(input logic [1:0] k, input logic w, input logic [AW-1:0] a,
                     input logic [1:0] s, input logic [3:0] b, input logic [31:0] d);
    while (!in_ready) begin @(posedge clk); #1; end
    in_valid = 1; in_kind = k; in_write = w; in_addr = a; in_size = s; in_be = b; in_data = d;
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic drain;
    out_ready = 1;
    for (int i = 0; i < 200 && expq.size() != 0; i++) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
    check(expq.size() == 0, "drain", 64'(expq.size()), 64'd0);
    out_ready = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      logic [EW-1:0] got;
      got = {out_kind, out_write, out_addr, out_size, out_be, out_data};
      if (expq.size() == 0) check(0, "unexpected", 64'(got), 64'd0);
      else begin
        logic [EW-1:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(got == e, t, 64'(got), 64'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid, "R1 out_valid", 64'(out_valid), 64'd0);
    check(in_ready, "R1 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1;
    @(posedge clk); #1;

    // R2 exact pass-through
    put(2'd1, 0, 16'h0200, 2'd2, 4'hF, 32'h0);
    put(2'd2, 1, 16'h0301, 2'd0, 4'h2, 32'h0000_AB00);
    put(2'd0, 1, 16'h0402, 2'd1, 4'hC, 32'h1234_0000);
    expect_tx("R2 dev", 2'd1, 0, 16'h0200, 2'd2, 4'hF, 32'h0);
    expect_tx("R2 so", 2'd2, 1, 16'h0301, 2'd0, 4'h2, 32'h0000_AB00);
    expect_tx("R2 norm", 2'd0, 1, 16'h0402, 2'd1, 4'hC, 32'h1234_0000);
    drain();

    // R4 R5: normal A, device B, device C, normal D -> AD, B, C
    put(2'd0, 1, 16'h0100, 2'd1, 4'h3, 32'h0000_1111);
    put(2'd1, 0, 16'h0200, 2'd2, 4'hF, 32'h0);
    put(2'd1, 1, 16'h0204, 2'd2, 4'hF, 32'hCAFE_0001);
    put(2'd0, 1, 16'h0102, 2'd1, 4'hC, 32'h2222_0000);
    expect_tx("R4 R5 merged", 2'd0, 1, 16'h0100, 2'd2, 4'hF, 32'h2222_1111);
    expect_tx("R3 R5 dev B", 2'd1, 0, 16'h0200, 2'd2, 4'hF, 32'h0);
    expect_tx("R3 R5 dev C", 2'd1, 1, 16'h0204, 2'd2, 4'hF, 32'hCAFE_0001);
    drain();

    // R4 reverse halves
    put(2'd0, 1, 16'h0112, 2'd1, 4'hC, 32'h5555_0000);
    put(2'd0, 1, 16'h0110, 2'd1, 4'h3, 32'h0000_6666);
    expect_tx("R4 reverse", 2'd0, 1, 16'h0110, 2'd2, 4'hF, 32'h5555_6666);
    drain();

    // R6 R3: strongly-ordered between halves -> ABCD
    put(2'd0, 1, 16'h0100, 2'd1, 4'h3, 32'h0000_1111);
    put(2'd2, 0, 16'h0200, 2'd2, 4'hF, 32'h0);
    put(2'd2, 1, 16'h0204, 2'd2, 4'hF, 32'h0000_0007);
    put(2'd0, 1, 16'h0102, 2'd1, 4'hC, 32'h2222_0000);
    expect_tx("R6 A", 2'd0, 1, 16'h0100, 2'd1, 4'h3, 32'h0000_1111);
    expect_tx("R3 R6 B", 2'd2, 0, 16'h0200, 2'd2, 4'hF, 32'h0);
    expect_tx("R3 R6 C", 2'd2, 1, 16'h0204, 2'd2, 4'hF, 32'h0000_0007);
    expect_tx("R6 D", 2'd0, 1, 16'h0102, 2'd1, 4'hC, 32'h2222_0000);
    drain();

    // R7 normal read of same word in between
    put(2'd0, 1, 16'h0300, 2'd1, 4'h3, 32'h0000_AAAA);
    put(2'd0, 0, 16'h0300, 2'd2, 4'hF, 32'h0);
    put(2'd0, 1, 16'h0302, 2'd1, 4'hC, 32'hBBBB_0000);
    expect_tx("R7 A", 2'd0, 1, 16'h0300, 2'd1, 4'h3, 32'h0000_AAAA);
    expect_tx("R7 read", 2'd0, 0, 16'h0300, 2'd2, 4'hF, 32'h0);
    expect_tx("R7 C", 2'd0, 1, 16'h0302, 2'd1, 4'hC, 32'hBBBB_0000);
    drain();

    // R8 reads, device halves, different words
    put(2'd0, 0, 16'h0400, 2'd1, 4'h3, 32'h0);
    put(2'd0, 0, 16'h0402, 2'd1, 4'hC, 32'h0);
    expect_tx("R8 read lo", 2'd0, 0, 16'h0400, 2'd1, 4'h3, 32'h0);
    expect_tx("R8 read hi", 2'd0, 0, 16'h0402, 2'd1, 4'hC, 32'h0);
    drain();
    put(2'd1, 1, 16'h0500, 2'd1, 4'h3, 32'h0000_0101);
    put(2'd1, 1, 16'h0502, 2'd1, 4'hC, 32'h0202_0000);
    expect_tx("R8 dev lo", 2'd1, 1, 16'h0500, 2'd1, 4'h3, 32'h0000_0101);
    expect_tx("R8 dev hi", 2'd1, 1, 16'h0502, 2'd1, 4'hC, 32'h0202_0000);
    drain();
    put(2'd0, 1, 16'h0600, 2'd1, 4'h3, 32'h0000_0303);
    put(2'd0, 1, 16'h0606, 2'd1, 4'hC, 32'h0404_0000);
    expect_tx("R8 word a", 2'd0, 1, 16'h0600, 2'd1, 4'h3, 32'h0000_0303);
    expect_tx("R8 word b", 2'd0, 1, 16'h0606, 2'd1, 4'hC, 32'h0404_0000);
    drain();

    // R9 R10 full and stall
    for (int i = 0; i < DEPTH; i++) begin
      put(2'd1, 0, 16'(16'h0700 + 4 * i), 2'd2, 4'hF, 32'h0);
      expect_tx("R9 R3 dev seq", 2'd1, 0, 16'(16'h0700 + 4 * i), 2'd2, 4'hF, 32'h0);
    end
    check(!in_ready, "R9 full", 64'(in_ready), 64'd0);
    repeat (3) @(posedge clk);
    #1;
    check(out_valid, "R10 valid held", 64'(out_valid), 64'd1);
    check(out_addr == 16'h0700, "R10 addr held", 64'(out_addr), 64'h0700);
    out_ready = 1;
    @(posedge clk); #1;
    out_ready = 0;
    check(in_ready, "R9 recover", 64'(in_ready), 64'd1);
    drain();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule